// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch

This block picks the clock that drives the rest of the chip. There are three sources: a primary oscillator, whose output may pass through a PLL; a fast internal oscillator, which is in use whenever its frequency field is non-zero or a force bit is set; and a slow internal RC clock. The block does not just multiplex these clocks. It starts the chosen source, waits until that source is proven stable, and only then moves the system clock onto it. Until that point the system keeps running on whatever clock it already has.

A start-up timer runs in the primary domain. It counts a fixed number of primary cycles. When the PLL is used, it then waits a further lock interval. A second timer in the fast domain counts the settling time of the fast oscillator. The handover between clocks is a request/acknowledge chain. A leg may ask for its gate only when every other leg's gate is off. Each leg's gate flop changes only on the falling edge of its own clock, behind a synchronizer. Two status flags report the state of the clocks. A run enable per oscillator tells the analog side which sources must keep running.

Top module: `clksw_ctrl`

## Requirements
- R1: `src_sel[1]`=1 selects the internal path, and `src_sel[1]`=0 (codes 00 and 01) selects the primary source. The internal path uses the fast oscillator when `freq_sel`!=0 or `ovr_fast`=1, and the slow RC clock otherwise. `fast_run_en` is 1 whenever that fast condition holds.
- R2: With `freq_sel`=0 and `ovr_fast`=0 on the internal path, `fast_stable` is 0 and `sys_clk` follows `clk_slow`.
- R3: Once the fast oscillator is enabled, `fast_stable` rises only after FAST_STAB_CYC fast cycles plus synchronization. During that interval `sys_clk` keeps toggling from the slow clock.
- R4: Once `fast_stable` is 1, it stays 1 while `freq_sel` moves between non-zero values. It also stays 1 while the primary source is selected but still starting.
- R5: After the primary source is selected, `sys_clk` stays on the internal path until OST_CYC primary cycles have been counted. When `pll_use`=1, a further PLL_LOCK_CYC primary cycles must also pass. Only then does `sys_clk` follow `clk_pri`.
- R6: When the switch onto the primary source is complete, `start_done`=1, `fast_stable`=0 and `pri_run_en`=1.
- R7: Deselecting the primary source clears `start_done` within 3 primary cycles. The start-up count restarts from zero when the primary source is selected again.
- R8: At most one source gate is open at a time. No high or low phase of `sys_clk` is shorter than the shortest half period of the sources.
- R9: `slow_run_en` is 1 whenever `wdt_en` or `fsm_en` is 1, even on the primary source. Otherwise it is 1 only while the slow clock is selected or still gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary oscillator clock (after the PLL, when one is used) |
| clk_fast | input | 1 | Fast internal oscillator divider output |
| clk_slow | input | 1 | Slow internal RC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select; bit 1 chooses the internal path |
| freq_sel | input | FREQ_W | Fast internal frequency field; zero turns the fast output off |
| ovr_fast | input | 1 | Forces the fast oscillator on while `freq_sel` is zero |
| pll_use | input | 1 | Adds the PLL lock wait to the primary start-up |
| wdt_en | input | 1 | Watchdog enable; keeps the slow clock running |
| fsm_en | input | 1 | Fail-safe monitor enable; keeps the slow clock running |
| sys_clk | output | 1 | Gated system clock |
| fast_stable | output | 1 | Fast internal oscillator is stable and the primary source is not in use |
| start_done | output | 1 | Primary start-up done and the primary source is driving `sys_clk` |
| pri_run_en | output | 1 | Run request for the primary oscillator |
| fast_run_en | output | 1 | Run request for the fast internal oscillator |
| slow_run_en | output | 1 | Run request for the slow RC clock |

## Verification
The bench checks that the switch waits for the full start-up count, with and without the PLL lock wait. A design that switched early would hand the system a clock that has not settled. The bench also deselects the primary source for a short time and then selects it again. A counter that failed to restart would then report `start_done` at once. The bench watches the stable flag across a change of `freq_sel` and during the primary start-up, where a design that cleared it early would drop the flag spuriously. A monitor measures every phase of `sys_clk`, so a gate that opened or closed on the wrong edge shows up as a short pulse.

// File: rtl/clksw_pkg.sv
`timescale 1ns/100ps
package clksw_pkg;

   // Leg numbering; the order is also the priority order of the selector
   localparam int LEG_N    = 3;
   localparam int LEG_PRI  = 0;
   localparam int LEG_FAST = 1;
   localparam int LEG_SLOW = 2;

   // Chooses one leg: primary when wanted and ready, else fast when stable, else slow
   function automatic logic [LEG_N-1:0] pick_leg(input logic use_int,
                                                 input logic pri_ok,
                                                 input logic fast_ok);
      logic [LEG_N-1:0] oh;
      oh = '0;
      if (!use_int && pri_ok)
         oh[LEG_PRI] = 1'b1;
      else if (fast_ok)
         oh[LEG_FAST] = 1'b1;
      else
         oh[LEG_SLOW] = 1'b1;
      return oh;
   endfunction

endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/100ps
module clksw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clksw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pipe <= '0;
      else
         pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksw_startup.sv
`timescale 1ns/100ps
module clksw_startup #(
   parameter int STAGE1_CYC  = 1024,
   parameter int STAGE2_CYC  = 1,
   parameter bit HAS_STAGE2  = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_req,
   input  logic stage2_en,
   output logic done
);
   localparam int TOTAL = STAGE1_CYC + (HAS_STAGE2 ? STAGE2_CYC : 0);
   localparam int CNT_W = $clog2(TOTAL + 1);
   localparam logic [CNT_W-1:0] LIM1 = CNT_W'(STAGE1_CYC - 1);
   localparam logic [CNT_W-1:0] LIM2 = CNT_W'(TOTAL - 1);

   generate
      if (STAGE1_CYC < 1) begin : g_bad_s1
         $error("clksw_startup: STAGE1_CYC must be at least 1");
      end
      if (HAS_STAGE2 && STAGE2_CYC < 1) begin : g_bad_s2
         $error("clksw_startup: STAGE2_CYC must be at least 1");
      end
   endgenerate

   logic             run_s;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   clksw_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (run_req),
      .q     (run_s)
   );

   generate
      if (HAS_STAGE2) begin : g_two_stage
         assign limit = stage2_en ? LIM2 : LIM1;
      end else begin : g_one_stage
         logic unused_stage2;
         assign unused_stage2 = stage2_en;
         assign limit = LIM1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!run_s) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (cnt == limit)
            done <= 1'b1;
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/clksw_leg.sv
`timescale 1ns/100ps
module clksw_leg #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_src,
   input  logic rst_n,
   input  logic req,
   output logic gate_en,
   output logic clk_gated
);
   logic req_s;

   clksw_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk_src),
      .rst_n (rst_n),
      .d     (req),
      .q     (req_s)
   );

   // Gate moves only while the source clock is low
   always_ff @(negedge clk_src or negedge rst_n) begin
      if (!rst_n)
         gate_en <= 1'b0;
      else
         gate_en <= req_s;
   end

   assign clk_gated = clk_src & gate_en;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/100ps
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int FREQ_W        = 3,
   parameter int OST_CYC       = 1024,
   parameter int PLL_LOCK_CYC  = 96000,
   parameter int FAST_STAB_CYC = 64,
   parameter int SYNC_STAGES   = 2
) (
   input  logic              clk_pri,
   input  logic              clk_fast,
   input  logic              clk_slow,
   input  logic              rst_n,
   input  logic [1:0]        src_sel,
   input  logic [FREQ_W-1:0] freq_sel,
   input  logic              ovr_fast,
   input  logic              pll_use,
   input  logic              wdt_en,
   input  logic              fsm_en,
   output logic              sys_clk,
   output logic              fast_stable,
   output logic              start_done,
   output logic              pri_run_en,
   output logic              fast_run_en,
   output logic              slow_run_en
);
   generate
      if (FREQ_W < 1) begin : g_bad_freq
         $error("clksw_ctrl: FREQ_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clksw_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             fast_want;
   logic             pri_want;
   logic             fast_ok;
   logic             pri_ok;
   logic [LEG_N-1:0] sel;
   logic [LEG_N-1:0] gate_en;
   logic [LEG_N-1:0] clk_vec;
   logic [LEG_N-1:0] gclk;

   assign fast_want = (|freq_sel) | ovr_fast;
   assign pri_want  = ~src_sel[1];

   clksw_startup #(
      .STAGE1_CYC  (FAST_STAB_CYC),
      .STAGE2_CYC  (1),
      .HAS_STAGE2  (1'b0),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fast_tmr (
      .clk       (clk_fast),
      .rst_n     (rst_n),
      .run_req   (fast_want),
      .stage2_en (1'b0),
      .done      (fast_ok)
   );

   clksw_startup #(
      .STAGE1_CYC  (OST_CYC),
      .STAGE2_CYC  (PLL_LOCK_CYC),
      .HAS_STAGE2  (1'b1),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pri_tmr (
      .clk       (clk_pri),
      .rst_n     (rst_n),
      .run_req   (pri_want),
      .stage2_en (pll_use),
      .done      (pri_ok)
   );

   assign sel = pick_leg(src_sel[1], pri_ok, fast_ok & fast_want);

   assign clk_vec[LEG_PRI]  = clk_pri;
   assign clk_vec[LEG_FAST] = clk_fast;
   assign clk_vec[LEG_SLOW] = clk_slow;

   generate
      for (genvar i = 0; i < LEG_N; i++) begin : g_leg
         logic [LEG_N-1:0] mask;
         logic             others_on;
         assign mask      = ~(LEG_N'(1) << i);
         assign others_on = |(gate_en & mask);
         clksw_leg #(.SYNC_STAGES(SYNC_STAGES)) u_leg (
            .clk_src   (clk_vec[i]),
            .rst_n     (rst_n),
            .req       (sel[i] & ~others_on),
            .gate_en   (gate_en[i]),
            .clk_gated (gclk[i])
         );
      end
   endgenerate

   assign sys_clk     = |gclk;
   assign fast_stable = fast_ok & ~gate_en[LEG_PRI];
   assign start_done  = pri_ok & gate_en[LEG_PRI];
   // Each source keeps running until its own gate has closed
   assign pri_run_en  = pri_want  | gate_en[LEG_PRI];
   assign fast_run_en = fast_want | gate_en[LEG_FAST];
   assign slow_run_en = sel[LEG_SLOW] | gate_en[LEG_SLOW] | wdt_en | fsm_en;
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/100ps
module clksw_chk #(
   parameter int FREQ_W = 3
) (
   input logic              clk_pri,
   input logic              clk_fast,
   input logic              rst_n,
   input logic [1:0]        src_sel,
   input logic [FREQ_W-1:0] freq_sel,
   input logic              ovr_fast,
   input logic              wdt_en,
   input logic              fsm_en,
   input logic [2:0]        gate,
   input logic              pri_ok,
   input logic              fast_stable,
   input logic              start_done,
   input logic              pri_run_en,
   input logic              slow_run_en
);
   logic fast_idle;
   assign fast_idle = (freq_sel == '0) && !ovr_fast;

   AST_ONE_GATE: assert property (@(posedge clk_fast) disable iff (!rst_n)
      $onehot0(gate)); // R8

   AST_SLOW_KEEP: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (wdt_en || fsm_en) |-> slow_run_en); // R9

   AST_FAST_IDLE_FLAG: assert property (@(posedge clk_fast) disable iff (!rst_n)
      (fast_idle && $past(fast_idle) && $past(fast_idle, 2) && $past(fast_idle, 3))
      |-> !fast_stable); // R2

   AST_PRI_AFTER_START: assert property (@(posedge clk_pri) disable iff (!rst_n)
      $rose(gate[0]) |-> pri_ok); // R5

   AST_DONE_FLAGS: assert property (@(posedge clk_pri) disable iff (!rst_n)
      start_done |-> (!fast_stable && pri_run_en)); // R6

   AST_DONE_CLEAR: assert property (@(posedge clk_pri) disable iff (!rst_n)
      (src_sel[1] && $past(src_sel[1]) && $past(src_sel[1], 2) && $past(src_sel[1], 3))
      |-> !start_done); // R7
endmodule

bind clksw_ctrl clksw_chk #(.FREQ_W(FREQ_W)) u_chk (
   .clk_pri     (clk_pri),
   .clk_fast    (clk_fast),
   .rst_n       (rst_n),
   .src_sel     (src_sel),
   .freq_sel    (freq_sel),
   .ovr_fast    (ovr_fast),
   .wdt_en      (wdt_en),
   .fsm_en      (fsm_en),
   .gate        (gate_en),
   .pri_ok      (pri_ok),
   .fast_stable (fast_stable),
   .start_done  (start_done),
   .pri_run_en  (pri_run_en),
   .slow_run_en (slow_run_en)
);

// File: tb/clksw_ctrl_bench.sv
`timescale 1ns/100ps
module clksw_ctrl_bench;
   localparam int FREQ_W = 3;
   localparam int OST    = 32;
   localparam int PLL    = 40;
   localparam int FSTAB  = 16;
   localparam int SETTLE = 150;

   logic clk_pri = 1'b0, clk_fast = 1'b0, clk_slow = 1'b0, rst_n = 1'b0;
   logic [1:0] src_sel = 2'b10;
   logic [FREQ_W-1:0] freq_sel = '0;
   logic ovr_fast = 1'b0, pll_use = 1'b0, wdt_en = 1'b0, fsm_en = 1'b0;
   logic sys_clk, fast_stable, start_done, pri_run_en, fast_run_en, slow_run_en;

   always #10 clk_pri  = ~clk_pri;   // 50 MHz
   always #6  clk_fast = ~clk_fast;
   always #35 clk_slow = ~clk_slow;

   clksw_ctrl #(
      .FREQ_W(FREQ_W), .OST_CYC(OST), .PLL_LOCK_CYC(PLL),
      .FAST_STAB_CYC(FSTAB), .SYNC_STAGES(2)
   ) u_clksw_ctrl (
      .clk_pri(clk_pri), .clk_fast(clk_fast), .clk_slow(clk_slow), .rst_n(rst_n),
      .src_sel(src_sel), .freq_sel(freq_sel), .ovr_fast(ovr_fast), .pll_use(pll_use),
      .wdt_en(wdt_en), .fsm_en(fsm_en), .sys_clk(sys_clk), .fast_stable(fast_stable),
      .start_done(start_done), .pri_run_en(pri_run_en), .fast_run_en(fast_run_en),
      .slow_run_en(slow_run_en)
   );

   int m_chk = 0, m_err = 0;      // directed checks
   int d_chk = 0, d_err = 0;      // settled reference model
   int p_chk = 0, p_err = 0;      // pulse-width monitor
   int wd_err = 0;
   int chg_id = 0;
   bit finished = 1'b0;

   task automatic report();
      $display("Result: errors=%0d of %0d checks",
               m_err + d_err + p_err + wd_err, m_chk + d_chk + p_chk + wd_err);
      $finish;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      m_chk++;
      if (act != exp) begin
         m_err++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic pri_cycles(input int n);
      repeat (n) @(posedge clk_pri);
      #0.5;
   endtask

   task automatic drive(input logic [1:0] s, input logic [FREQ_W-1:0] f,
                        input logic o, input logic p, input logic w, input logic m);
      src_sel = s; freq_sel = f; ovr_fast = o; pll_use = p; wdt_en = w; fsm_en = m;
      chg_id++;
   endtask

   // 0 = primary, 1 = fast, 2 = slow; returns the number of mismatching samples
   task automatic follow(input int leg, output int mis);
      logic ref_clk;
      mis = 0;
      for (int k = 0; k < 20; k++) begin
         #2;
         ref_clk = (leg == 0) ? clk_pri : (leg == 1) ? clk_fast : clk_slow;
         if (sys_clk !== ref_clk) mis++;
      end
   endtask

   // Behavioural reference of the settled state, compared every primary cycle
   int quiet = 0, seen_id = 0;
   always begin
      @(posedge clk_pri);
      #0.5;
      if (!rst_n || seen_id != chg_id) begin
         quiet = 0;
         seen_id = chg_id;
      end else if (quiet < SETTLE) begin
         quiet++;
      end else begin
         bit on_pri, fw, on_slow;
         logic [4:0] e, a;
         on_pri  = !src_sel[1];
         fw      = (freq_sel != 0) || ovr_fast;
         on_slow = !on_pri && !fw;
         e = {fw && !on_pri, on_pri, on_pri, fw, on_slow || wdt_en || fsm_en};
         a = {fast_stable, start_done, pri_run_en, fast_run_en, slow_run_en};
         d_chk++;
         if (a !== e) begin
            d_err++;
            $display("FAIL R1,R2,R6,R9 settled flags: actual=%b expected=%b", a, e);
         end
      end
   end

   // R8: no phase of sys_clk shorter than the fastest half period (6 ns)
   realtime last_edge = 0.0;
   always @(sys_clk) begin
      if (rst_n && last_edge > 0.0) begin
         p_chk++;
         if ($realtime - last_edge < 6.0) begin
            p_err++;
            $display("FAIL R8 phase width: actual=%0t expected>=6ns", $realtime - last_edge);
         end
      end
      last_edge = $realtime;
   end

   initial begin
      #4_000_000;
      if (!finished) begin
         wd_err = 1;
         $display("FAIL watchdog: actual=running expected=finished");
         report();
      end
   end

   initial begin
      int mis;
      #50.5;
      chk("R8", "sys_clk in reset", sys_clk, 0);
      chk("R2", "fast_stable in reset", fast_stable, 0);
      chk("R6", "start_done in reset", start_done, 0);
      #50;
      rst_n = 1'b1;
      pri_cycles(30);
      follow(2, mis);            chk("R2", "follows slow after reset", mis, 0);
      chk("R2", "fast_stable idle", fast_stable, 0);
      chk("R1", "fast_run_en idle", fast_run_en, 0);

      // Fast oscillator start-up
      drive(2'b10, 3'b100, 0, 0, 0, 0);
      #0.5;
      chk("R1", "fast_run_en on freq", fast_run_en, 1);
      #72;
      chk("R3", "fast_stable early", fast_stable, 0);
      follow(2, mis);            chk("R3", "clocks during settling", mis, 0);
      chk("R3", "fast_stable still early", fast_stable, 0);
      pri_cycles(40);
      chk("R3", "fast_stable after settling", fast_stable, 1);
      follow(1, mis);            chk("R1", "follows fast", mis, 0);

      // Frequency change between non-zero values
      drive(2'b10, 3'b011, 0, 0, 0, 0);
      mis = 0;
      for (int k = 0; k < 150; k++) begin
         #2;
         if (fast_stable !== 1'b1) mis++;
      end
      chk("R4", "stable across freq change", mis, 0);

      // Primary without PLL
      drive(2'b00, 3'b011, 0, 0, 0, 0);
      pri_cycles(OST - 4);
      chk("R5", "start_done before count", start_done, 0);
      chk("R4", "stable while primary starts", fast_stable, 1);
      follow(1, mis);            chk("R5", "still on fast", mis, 0);
      pri_cycles(30);
      follow(0, mis);            chk("R5", "follows primary", mis, 0);
      chk("R6", "start_done set", start_done, 1);
      chk("R6", "fast_stable cleared", fast_stable, 0);
      chk("R6", "pri_run_en", pri_run_en, 1);
      chk("R9", "slow off on primary", slow_run_en, 0);
      drive(2'b00, 3'b011, 0, 0, 1, 0);
      #0.5;
      chk("R9", "slow on with watchdog", slow_run_en, 1);
      drive(2'b00, 3'b011, 0, 0, 0, 1);
      #0.5;
      chk("R9", "slow on with fail-safe", slow_run_en, 1);

      // Leave primary
      drive(2'b10, 3'b011, 0, 0, 0, 0);
      pri_cycles(5);
      chk("R7", "start_done cleared", start_done, 0);
      pri_cycles(20);
      follow(1, mis);            chk("R1", "back on fast", mis, 0);
      chk("R7", "pri_run_en off", pri_run_en, 0);
      chk("R4", "fast_stable back", fast_stable, 1);

      // Primary with PLL lock wait
      drive(2'b00, 3'b011, 0, 1, 0, 0);
      pri_cycles(OST + PLL - 8);
      chk("R5", "start_done before PLL lock", start_done, 0);
      follow(1, mis);            chk("R5", "on fast during PLL lock", mis, 0);
      pri_cycles(40);
      follow(0, mis);            chk("R5", "on primary after PLL lock", mis, 0);
      chk("R6", "start_done after PLL lock", start_done, 1);

      // Counter restart after a short deselect
      drive(2'b10, 3'b011, 0, 0, 0, 0);
      pri_cycles(12);
      drive(2'b00, 3'b011, 0, 0, 0, 0);
      pri_cycles(OST - 4);
      chk("R7", "count restarted", start_done, 0);
      follow(1, mis);            chk("R7", "on fast after restart", mis, 0);
      pri_cycles(30);
      chk("R7", "start_done after restart", start_done, 1);

      // Back to idle internal, then override
      drive(2'b10, 3'b000, 0, 0, 0, 0);
      pri_cycles(40);
      chk("R2", "fast_stable idle again", fast_stable, 0);
      chk("R1", "fast_run_en idle again", fast_run_en, 0);
      follow(2, mis);            chk("R2", "follows slow again", mis, 0);
      pri_cycles(200);
      drive(2'b10, 3'b000, 1, 0, 0, 0);
      #0.5;
      chk("R1", "override enables fast", fast_run_en, 1);
      pri_cycles(40);
      chk("R3", "stable under override", fast_stable, 1);
      follow(1, mis);            chk("R1", "follows fast under override", mis, 0);

      // Code 01 counts as primary
      drive(2'b01, 3'b000, 1, 0, 0, 0);
      pri_cycles(60);
      follow(0, mis);            chk("R1", "code 01 selects primary", mis, 0);
      pri_cycles(200);

      finished = 1'b1;
      report();
   end
endmodule